// File: doc/BRIEF.md
# Two-Level Masked Interrupt Aggregator

This block collects interrupt events into a main 32-bit pending word and two subordinate pending groups. One group serves a USB core and is 32 bits wide. The other serves DMA completion and is `DMA_W` bits wide. Each group has four word addresses on a simple synchronous register bus: source, set, clear and mask. Each subordinate group is reduced to summary bits that appear at fixed positions of the main pending word. The USB group's lower and upper halves feed separate summary bits. The main word, its mask, a polarity bit and an external allow gate together drive one registered interrupt line.

Software raises and retires pending bits with write-one-to-set and write-one-to-clear accesses. Hardware raises them through per-bit event inputs. Reads are combinational from the current state. With polarity set, the line rises when something unmasked is pending. With polarity clear, the line is high only while nothing unmasked is pending. In both cases the allow input must be high.

Top module: `irq_aggregator`

## Requirements
- R1: A write to a group's set address (main 0x1, USB 0x5, DMA 0x9) ORs the write data into that group's pending bits. The DMA group keeps only write bits `DMA_W-1:0` (default 16).
- R2: A write to a group's clear address (main 0x2, USB 0x6, DMA 0xA) clears the pending bits whose data bit is 1 and leaves the other bits unchanged.
- R3: A read of a group's source, set or clear address (main 0x0-0x2, USB 0x4-0x6, DMA 0x8-0xA) returns that group's pending bits. A read of its mask address (0x3, 0x7, 0xB) returns the mask.
- R4: Main pending bit 9 is 1 exactly when some USB pending bit in 15:0 is 1 with its mask bit 0. Main bit 8 is the same for USB bits 31:16. Both follow a USB set, clear or mask write with no extra delay.
- R5: Main pending bit 24 is 1 exactly when some DMA pending bit is 1 with its mask bit 0.
- R6: Main bits 24, 9 and 8 cannot be set or cleared by main set/clear writes or by main event inputs. Only the summaries drive them.
- R7: Configuration address 0xC holds the polarity in bit 17 and reads back only that bit. With polarity 1, the line is 1 when an unmasked main bit is pending and allow is 1.
- R8: With polarity 0, the line is 1 when no unmasked main bit is pending and allow is 1. Otherwise it is 0.
- R9: Reset sets the main mask to all ones and clears the subordinate masks, all pending bits, the polarity and the line.
- R10: An event input bit sets its pending bit at the clock edge where it is seen. If a clear write hits the same bit at that edge, the bit ends up set.
- R11: The line is registered. It reflects the state one clock edge after that state changed.
- R12: Writes to unused addresses 0xD-0xF change no state. Reads of them return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| main_evt_i | input | 32 | Event inputs for main pending bits |
| usb_evt_i | input | USB_W | Event inputs for USB group bits |
| dma_evt_i | input | DMA_W | Event inputs for DMA group bits |
| allow_i | input | 1 | External gate on the interrupt line |
| irq_o | output | 1 | Registered interrupt line |

## Verification
The assertions assume that every input is synchronous to `clk` and stable across each rising edge. They also assume that only one register address is written per cycle. The bench meets both conditions by changing all inputs on the falling edge and holding a write for exactly one cycle. Event inputs are driven together with a clear write only on purpose, to exercise the set-over-clear priority. The R2 property leaves such event bits out of its expectation.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] A_MAIN_SRC  = 4'h0;
    localparam logic [ADDR_W-1:0] A_MAIN_SET  = 4'h1;
    localparam logic [ADDR_W-1:0] A_MAIN_CLR  = 4'h2;
    localparam logic [ADDR_W-1:0] A_MAIN_MASK = 4'h3;
    localparam logic [ADDR_W-1:0] A_USB_SRC   = 4'h4;
    localparam logic [ADDR_W-1:0] A_USB_SET   = 4'h5;
    localparam logic [ADDR_W-1:0] A_USB_CLR   = 4'h6;
    localparam logic [ADDR_W-1:0] A_USB_MASK  = 4'h7;
    localparam logic [ADDR_W-1:0] A_DMA_SRC   = 4'h8;
    localparam logic [ADDR_W-1:0] A_DMA_SET   = 4'h9;
    localparam logic [ADDR_W-1:0] A_DMA_CLR   = 4'hA;
    localparam logic [ADDR_W-1:0] A_DMA_MASK  = 4'hB;
    localparam logic [ADDR_W-1:0] A_CFG       = 4'hC;

    // Summary bit positions inside the main pending word
    localparam int POS_USB_LO = 9;
    localparam int POS_USB_HI = 8;
    localparam int POS_DMA    = 24;
    localparam int POS_POL    = 17;

    localparam logic [DATA_W-1:0] SUM_BITS = (32'd1 << POS_DMA)
                                           | (32'd1 << POS_USB_LO)
                                           | (32'd1 << POS_USB_HI);

    typedef struct packed {
        logic set_we;
        logic clr_we;
        logic mask_we;
    } grp_we_t;
endpackage

// File: rtl/irq_subgroup.sv
module irq_subgroup
    import irq_agg_pkg::*;
#(
    parameter int           W        = 32,
    parameter bit           SPLIT    = 1'b0,
    parameter logic [W-1:0] MASK_RST = '0,
    parameter int           SUM_W    = SPLIT ? 2 : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  grp_we_t          we,
    input  logic [W-1:0]     wdata,
    input  logic [W-1:0]     evt,
    output logic [W-1:0]     pend_o,
    output logic [W-1:0]     mask_o,
    output logic [SUM_W-1:0] sum_o
);
    logic [W-1:0] pend_q, pend_d, mask_q, active;

    always_comb begin
        pend_d = pend_q;
        if (we.set_we) pend_d = pend_d | wdata;
        if (we.clr_we) pend_d = pend_d & ~wdata;
        pend_d = pend_d | evt;          // hardware events take priority
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            mask_q <= MASK_RST;
        end else begin
            pend_q <= pend_d;
            if (we.mask_we) mask_q <= wdata;
        end
    end

    assign active = pend_q & ~mask_q;
    assign pend_o = pend_q;
    assign mask_o = mask_q;

    generate
        if (SPLIT) begin : g_halves
            localparam int H = W / 2;
            // sum_o[0] covers the lower half, sum_o[1] the upper half
            assign sum_o = SUM_W'({|active[W-1:H], |active[H-1:0]});
        end else begin : g_whole
            assign sum_o = SUM_W'(|active);
        end
    endgenerate
endmodule

// File: rtl/irq_line.sv
module irq_line (
    input  logic clk,
    input  logic rst_n,
    input  logic pol,
    input  logic allow,
    input  logic active,
    output logic irq_o
);
    logic level;

    always_comb begin
        if (pol) level = active & allow;
        else     level = ~active & allow;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= level;
    end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int USB_W = 32,
    parameter int DMA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] main_evt_i,
    input  logic [USB_W-1:0]  usb_evt_i,
    input  logic [DMA_W-1:0]  dma_evt_i,
    input  logic              allow_i,
    output logic              irq_o
);
    grp_we_t we_main, we_usb, we_dma;
    logic    cfg_we;
    logic    cfg_pol;

    logic [DATA_W-1:0] main_q, main_mask, main_pend;
    logic [0:0]        main_sum;
    logic [USB_W-1:0]  usb_pend, usb_mask;
    logic [1:0]        usb_sum;
    logic [DMA_W-1:0]  dma_pend, dma_mask;
    logic [0:0]        dma_sum;
    logic              sum_active, any_active;

    // Write decode
    always_comb begin
        we_main = '0;
        we_usb  = '0;
        we_dma  = '0;
        cfg_we  = 1'b0;
        if (bus_wr) begin
            unique case (bus_addr)
                A_MAIN_SET:  we_main.set_we  = 1'b1;
                A_MAIN_CLR:  we_main.clr_we  = 1'b1;
                A_MAIN_MASK: we_main.mask_we = 1'b1;
                A_USB_SET:   we_usb.set_we   = 1'b1;
                A_USB_CLR:   we_usb.clr_we   = 1'b1;
                A_USB_MASK:  we_usb.mask_we  = 1'b1;
                A_DMA_SET:   we_dma.set_we   = 1'b1;
                A_DMA_CLR:   we_dma.clr_we   = 1'b1;
                A_DMA_MASK:  we_dma.mask_we  = 1'b1;
                A_CFG:       cfg_we          = 1'b1;
                default:     ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cfg_pol <= 1'b0;
        else if (cfg_we) cfg_pol <= bus_wdata[POS_POL];
    end

    // Main group: summary positions are stripped from its write and event
    // paths. The mask path is left whole, since the main mask also gates
    // the summaries.
    irq_subgroup #(.W(DATA_W), .SPLIT(1'b0), .MASK_RST('1)) u_main (
        .clk(clk), .rst_n(rst_n), .we(we_main),
        .wdata(we_main.mask_we ? bus_wdata : (bus_wdata & ~SUM_BITS)),
        .evt(main_evt_i & ~SUM_BITS),
        .pend_o(main_q), .mask_o(main_mask), .sum_o(main_sum)
    );

    irq_subgroup #(.W(USB_W), .SPLIT(1'b1), .MASK_RST('0)) u_usb (
        .clk(clk), .rst_n(rst_n), .we(we_usb),
        .wdata(bus_wdata[USB_W-1:0]), .evt(usb_evt_i),
        .pend_o(usb_pend), .mask_o(usb_mask), .sum_o(usb_sum)
    );

    irq_subgroup #(.W(DMA_W), .SPLIT(1'b0), .MASK_RST('0)) u_dma (
        .clk(clk), .rst_n(rst_n), .we(we_dma),
        .wdata(bus_wdata[DMA_W-1:0]), .evt(dma_evt_i),
        .pend_o(dma_pend), .mask_o(dma_mask), .sum_o(dma_sum)
    );

    always_comb begin
        main_pend             = main_q;
        main_pend[POS_USB_LO] = usb_sum[0];
        main_pend[POS_USB_HI] = usb_sum[1];
        main_pend[POS_DMA]    = dma_sum[0];
    end

    assign sum_active = |(main_pend & ~main_mask & SUM_BITS);
    assign any_active = main_sum[0] | sum_active;

    irq_line u_line (
        .clk(clk), .rst_n(rst_n), .pol(cfg_pol), .allow(allow_i),
        .active(any_active), .irq_o(irq_o)
    );

    // Read mux
    always_comb begin
        unique case (bus_addr)
            A_MAIN_SRC, A_MAIN_SET, A_MAIN_CLR: bus_rdata = main_pend;
            A_MAIN_MASK:                        bus_rdata = main_mask;
            A_USB_SRC, A_USB_SET, A_USB_CLR:    bus_rdata = DATA_W'(usb_pend);
            A_USB_MASK:                         bus_rdata = DATA_W'(usb_mask);
            A_DMA_SRC, A_DMA_SET, A_DMA_CLR:    bus_rdata = DATA_W'(dma_pend);
            A_DMA_MASK:                         bus_rdata = DATA_W'(dma_mask);
            A_CFG:                              bus_rdata = DATA_W'(cfg_pol) << POS_POL;
            default:                            bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
    import irq_agg_pkg::*;
#(
    parameter int USB_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] main_evt_i,
    input logic [USB_W-1:0]  usb_evt_i,
    input logic              allow_i,
    input logic              irq_o,
    input logic [DATA_W-1:0] main_pend,
    input logic [DATA_W-1:0] main_mask,
    input logic [USB_W-1:0]  usb_pend,
    input logic              cfg_pol
);
    logic seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    AST_USB_SET_OR: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && bus_wr && bus_addr == A_USB_SET |=>
        (usb_pend & $past(bus_wdata[USB_W-1:0])) == $past(bus_wdata[USB_W-1:0])); // R1

    AST_USB_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && bus_wr && bus_addr == A_USB_CLR |=>
        (usb_pend & $past(bus_wdata[USB_W-1:0]) & ~$past(usb_evt_i)) == '0); // R2

    AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && (|(main_evt_i & ~SUM_BITS)) |=>
        (main_pend & $past(main_evt_i & ~SUM_BITS)) == $past(main_evt_i & ~SUM_BITS)); // R10

    AST_IRQ_ACTIVE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && cfg_pol |=>
        irq_o == ($past(allow_i) && (|$past(main_pend & ~main_mask)))); // R7

    AST_IRQ_ACTIVE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && !cfg_pol |=>
        irq_o == ($past(allow_i) && !(|$past(main_pend & ~main_mask)))); // R8
endmodule

bind irq_aggregator irq_agg_chk #(.USB_W(USB_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .main_evt_i(main_evt_i), .usb_evt_i(usb_evt_i),
    .allow_i(allow_i), .irq_o(irq_o), .main_pend(main_pend),
    .main_mask(main_mask), .usb_pend(usb_pend), .cfg_pol(cfg_pol)
);

// File: tb/tb_irq_aggregator.sv
module tb_irq_aggregator;
    import irq_agg_pkg::*;

    localparam int USB_W = 32;
    localparam int DMA_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic [DATA_W-1:0] main_evt_i = '0;
    logic [USB_W-1:0]  usb_evt_i = '0;
    logic [DMA_W-1:0]  dma_evt_i = '0;
    logic              allow_i = 1'b0;
    logic              irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_aggregator #(.USB_W(USB_W), .DMA_W(DMA_W)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .main_evt_i(main_evt_i),
        .usb_evt_i(usb_evt_i), .dma_evt_i(dma_evt_i), .allow_i(allow_i),
        .irq_o(irq_o)
    );

    typedef struct packed {
        logic [3:0]        req;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VECS [NV] = '{
        '{4'd1,  1'b1, A_USB_SET,  32'h0003_0001},  // R1
        '{4'd1,  1'b0, A_USB_SRC,  32'h0003_0001},  // R1
        '{4'd4,  1'b0, A_MAIN_SRC, 32'h0000_0300},  // R4 both halves
        '{4'd4,  1'b1, A_USB_MASK, 32'h0000_FFFF},  // R4
        '{4'd4,  1'b0, A_MAIN_SRC, 32'h0000_0100},  // R4 lower half masked
        '{4'd3,  1'b0, A_USB_CLR,  32'h0003_0001},  // R3
        '{4'd3,  1'b0, A_USB_MASK, 32'h0000_FFFF},  // R3
        '{4'd2,  1'b1, A_USB_CLR,  32'h0001_0000},  // R2
        '{4'd3,  1'b0, A_USB_SET,  32'h0002_0001},  // R3 / R2
        '{4'd4,  1'b0, A_MAIN_SRC, 32'h0000_0100},  // R4
        '{4'd1,  1'b1, A_DMA_SET,  32'h8000_0005},  // R1 truncation
        '{4'd1,  1'b0, A_DMA_SRC,  32'h0000_0005},  // R1
        '{4'd5,  1'b0, A_MAIN_SRC, 32'h0100_0100},  // R5
        '{4'd5,  1'b1, A_DMA_MASK, 32'h0000_0005},  // R5
        '{4'd5,  1'b0, A_MAIN_SRC, 32'h0000_0100},  // R5
        '{4'd6,  1'b1, A_MAIN_SET, 32'h0100_8301},  // R6
        '{4'd6,  1'b0, A_MAIN_SRC, 32'h0000_8101},  // R6
        '{4'd2,  1'b1, A_MAIN_CLR, 32'h0000_0101},  // R2
        '{4'd6,  1'b0, A_MAIN_SRC, 32'h0000_8100},  // R6 summary untouched
        '{4'd7,  1'b1, A_CFG,      32'hFFFF_FFFF},  // R7
        '{4'd7,  1'b0, A_CFG,      32'h0002_0000},  // R7
        '{4'd12, 1'b1, 4'hD,       32'h0000_1234},  // R12
        '{4'd12, 1'b0, 4'hD,       32'h0000_0000},  // R12
        '{4'd12, 1'b0, A_MAIN_SRC, 32'h0000_8100},  // R12
        '{4'd9,  1'b0, A_MAIN_MASK,32'hFFFF_FFFF}   // R9
    };

    task automatic check(input int req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL R%0d %s: actual=%08h expected=%08h", req, what, got, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_check(input int req, input string what,
                            input logic [ADDR_W-1:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        check(req, what, bus_rdata, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        // R9: reset state
        repeat (2) @(negedge clk);
        rd_check(9, "main mask at reset", A_MAIN_MASK, 32'hFFFF_FFFF);
        rd_check(9, "usb mask at reset", A_USB_MASK, 32'h0);
        rd_check(9, "dma pend at reset", A_DMA_SRC, 32'h0);
        rd_check(9, "cfg at reset", A_CFG, 32'h0);
        check(9, "irq at reset", 32'(irq_o), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) wr(VECS[i].addr, VECS[i].data);
            else rd_check(int'(VECS[i].req), $sformatf("vector %0d", i),
                          VECS[i].addr, VECS[i].data);
        end

        // Line behaviour from a fresh reset
        do_reset();
        allow_i = 1'b1;
        @(negedge clk);
        check(8, "idle, polarity 0", 32'(irq_o), 32'h1);          // R8
        wr(A_MAIN_MASK, 32'h0);
        wr(A_MAIN_SET, 32'h0000_0008);
        check(11, "line holds one edge", 32'(irq_o), 32'h1);      // R11
        @(negedge clk);
        check(8, "pending drops line", 32'(irq_o), 32'h0);        // R8
        wr(A_CFG, 32'h0002_0000);
        check(11, "line after pol write", 32'(irq_o), 32'h0);     // R11
        @(negedge clk);
        check(7, "pol 1 pending", 32'(irq_o), 32'h1);             // R7
        allow_i = 1'b0;
        @(negedge clk);
        check(7, "allow gate low", 32'(irq_o), 32'h0);            // R7
        allow_i = 1'b1;
        @(negedge clk);
        check(7, "allow gate high", 32'(irq_o), 32'h1);           // R7
        wr(A_MAIN_MASK, 32'h0000_0008);
        @(negedge clk);
        check(7, "masked bit", 32'(irq_o), 32'h0);                // R7

        // R10: event beats clear on the same edge
        main_evt_i = 32'h0000_8000;
        wr(A_MAIN_CLR, 32'h0000_8008);
        main_evt_i = '0;
        rd_check(10, "event vs clear", A_MAIN_SRC, 32'h0000_8000);
        wr(A_MAIN_CLR, 32'h0000_8000);
        rd_check(2, "clear alone", A_MAIN_SRC, 32'h0);

        // R6: event on a summary position is ignored
        main_evt_i = 32'h0000_0200;
        @(negedge clk);
        main_evt_i = '0;
        rd_check(6, "event at summary bit", A_MAIN_SRC, 32'h0);

        // R10: USB event vs USB clear, and R4 summary follows
        usb_evt_i = 32'h0000_0004;
        wr(A_USB_CLR, 32'h0000_0004);
        usb_evt_i = '0;
        rd_check(10, "usb event vs clear", A_USB_SRC, 32'h0000_0004);
        rd_check(4, "usb lower summary", A_MAIN_SRC, 32'h0000_0200);

        // R1: DMA event path
        dma_evt_i = 16'h8000;
        @(negedge clk);
        dma_evt_i = '0;
        rd_check(10, "dma event", A_DMA_SRC, 32'h0000_8000);
        rd_check(5, "dma summary", A_MAIN_SRC, 32'h0100_0200);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule